// File: doc/BRIEF.md
# Address-match busy arbiter

This block sits beside a two-port memory core and watches what each port is selecting. A port selects a location when its active-low enable is low. When both ports select the same address at once, the block picks the port that settled on its access first as the winner. It flags the other port busy (active low) and blocks that port's writes. When neither port settled first, the left port wins. Only one port can ever be flagged.

Arrival order is tracked in clock cycles. For each port, the block counts how many cycles its enable-and-address combination has stayed unchanged, and the counter saturates at its limit. The winner of a contention episode is fixed in the cycle the episode starts and stays fixed until the episode ends. The busy flags are registered and lag the contention by one cycle. The write-gate outputs that feed the memory core act in the same cycle as the contention, so no write from the losing port can reach the array.

Top module: `address_busy_arbiter`

## Requirements
- R1: When the two addresses differ, both busy outputs are high (1) in the next cycle, and both write gates are 1.
- R2: When either enable is high (1), both busy outputs are high in the next cycle, and both write gates are 1, whether or not the addresses match.
- R3: When both enables are low and the addresses are equal, the port whose enable-and-address value has been unchanged for more cycles wins. The other port's busy output goes low one clock edge after the first contention cycle.
- R4: When both ports changed their enable-and-address value in the same cycle that contention begins, the left port wins and the right busy output goes low.
- R5: The two busy outputs are never low at the same time.
- R6: In every contention cycle, exactly one write gate is 0, and it belongs to the losing port. This takes effect in the same cycle, before the busy output changes.
- R7: The winner chosen when an episode starts is kept for as long as contention lasts without a break. This holds even after both unchanged-cycle counters have saturated.
- R8: When contention ends, the losing write gate returns to 1 in the same cycle, and the busy output returns high one clock edge later.
- R9: During reset and after it, both busy outputs are high until contention is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrLeft | input | 11 | Left port address |
| enLeftN | input | 1 | Left port enable, active low |
| addrRight | input | 11 | Right port address |
| enRightN | input | 1 | Right port enable, active low |
| busyLeftN | output | 1 | Left busy flag, registered, active low |
| busyRightN | output | 1 | Right busy flag, registered, active low |
| wrGateLeft | output | 1 | 1 when left writes may reach the core |
| wrGateRight | output | 1 | 1 when right writes may reach the core |

## Verification
The hardest case to reach is a long contention episode in which the right port arrived first. After enough cycles both unchanged-cycle counters saturate, and a design that re-arbitrated every cycle would quietly hand the win to the left port. To reach it, the stimulus parks the right port on an address and then moves the left port onto the same address. It holds both steady for more cycles than the counter limit, checking the flags and gates every cycle. Ties are produced by moving both ports onto a fresh common address in the same cycle.

// File: rtl/busy_arb_pkg.sv
package busy_arb_pkg;
  typedef struct packed {
    logic contend;   // both enabled, same address, this cycle
    logic leftOlder; // left value unchanged at least as long as right
  } senseT;
endpackage

// File: rtl/busy_arb_sense.sv
module busy_arb_sense
  import busy_arb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int AGE_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrLeft,
  input  logic              enLeftN,
  input  logic [ADDR_W-1:0] addrRight,
  input  logic              enRightN,
  output senseT             sense
);
  localparam int KEY_W = ADDR_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam int PORTS = 2;

  logic [PORTS-1:0][KEY_W-1:0] keyNow;
  logic [PORTS-1:0][KEY_W-1:0] keyQ;
  logic [PORTS-1:0][AGE_W-1:0] ageQ;
  logic [PORTS-1:0][AGE_W-1:0] ageNow;

  assign keyNow[0] = {enLeftN, addrLeft};
  assign keyNow[1] = {enRightN, addrRight};

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic changed;
    always_comb begin
      changed = (keyNow[p] != keyQ[p]);
      if (changed)                ageNow[p] = '0;
      else if (ageQ[p] == AGE_MAX) ageNow[p] = AGE_MAX;
      else                        ageNow[p] = ageQ[p] + 1'b1;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        keyQ[p] <= {1'b1, {ADDR_W{1'b0}}};
        ageQ[p] <= '0;
      end else begin
        keyQ[p] <= keyNow[p];
        ageQ[p] <= ageNow[p];
      end
    end
  end

  always_comb begin
    sense.contend   = !enLeftN && !enRightN && (addrLeft == addrRight);
    sense.leftOlder = (ageNow[0] >= ageNow[1]);
  end
endmodule

// File: rtl/busy_arb_ctrl.sv
module busy_arb_ctrl
  import busy_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  senseT sense,
  output logic  busyLeftN,
  output logic  busyRightN,
  output logic  wrGateLeft,
  output logic  wrGateRight
);
  logic episodeQ;
  logic winLeftQ;
  logic winLeft;

  always_comb begin
    winLeft     = episodeQ ? winLeftQ : sense.leftOlder;
    wrGateLeft  = !(sense.contend && !winLeft);
    wrGateRight = !(sense.contend && winLeft);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      episodeQ   <= 1'b0;
      winLeftQ   <= 1'b1;
      busyLeftN  <= 1'b1;
      busyRightN <= 1'b1;
    end else begin
      episodeQ   <= sense.contend;
      winLeftQ   <= winLeft;
      busyLeftN  <= wrGateLeft;
      busyRightN <= wrGateRight;
    end
  end
endmodule

// File: rtl/address_busy_arbiter.sv
module address_busy_arbiter
  import busy_arb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int AGE_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrLeft,
  input  logic              enLeftN,
  input  logic [ADDR_W-1:0] addrRight,
  input  logic              enRightN,
  output logic              busyLeftN,
  output logic              busyRightN,
  output logic              wrGateLeft,
  output logic              wrGateRight
);
  senseT sense;

  busy_arb_sense #(.ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_sense (
    .clk(clk), .rstN(rstN),
    .addrLeft(addrLeft), .enLeftN(enLeftN),
    .addrRight(addrRight), .enRightN(enRightN),
    .sense(sense)
  );

  busy_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sense(sense),
    .busyLeftN(busyLeftN), .busyRightN(busyRightN),
    .wrGateLeft(wrGateLeft), .wrGateRight(wrGateRight)
  );
endmodule

// File: rtl/address_busy_arbiter_chk.sv
module address_busy_arbiter_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrLeft,
  input logic              enLeftN,
  input logic [ADDR_W-1:0] addrRight,
  input logic              enRightN,
  input logic              busyLeftN,
  input logic              busyRightN,
  input logic              wrGateLeft,
  input logic              wrGateRight
);
  logic clash;
  assign clash = !enLeftN && !enRightN && (addrLeft == addrRight);

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busyLeftN || busyRightN); // R5
  AST_DIFF_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (addrLeft != addrRight) |=> (busyLeftN && busyRightN)); // R1
  AST_ENABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (enLeftN || enRightN) |=> (busyLeftN && busyRightN)); // R2
  AST_ONE_GATE_SHUT: assert property (@(posedge clk) disable iff (!rstN)
    clash |-> ($countones({wrGateLeft, wrGateRight}) == 1)); // R6
  AST_GATES_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    !clash |-> (wrGateLeft && wrGateRight)); // R8
  AST_BUSY_FOLLOWS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (busyLeftN == $past(wrGateLeft))); // R3
  AST_WINNER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (clash && $past(clash) && $past(rstN)) |-> $stable(wrGateLeft)); // R7
endmodule

bind address_busy_arbiter address_busy_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_address_busy_arbiter.sv
module tb_address_busy_arbiter;
  localparam int ADDR_W = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] addrLeft = '0;
  logic [ADDR_W-1:0] addrRight = '0;
  logic enLeftN = 1'b1;
  logic enRightN = 1'b1;
  logic busyLeftN, busyRightN, wrGateLeft, wrGateRight;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] exp; // {busyL, busyR, gateL, gateR}
    string      tag;
  } itemT;
  itemT queueQ[$];

  always #2 clk = ~clk;

  address_busy_arbiter dut (
    .clk(clk), .rstN(rstN),
    .addrLeft(addrLeft), .enLeftN(enLeftN),
    .addrRight(addrRight), .enRightN(enRightN),
    .busyLeftN(busyLeftN), .busyRightN(busyRightN),
    .wrGateLeft(wrGateLeft), .wrGateRight(wrGateRight)
  );

  // Driver: apply inputs on the falling edge, push what the ports must show
  task automatic step(input int aL, input logic eL, input int aR, input logic eR,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    addrLeft = aL[ADDR_W-1:0]; enLeftN = eL;
    addrRight = aR[ADDR_W-1:0]; enRightN = eR;
    queueQ.push_back('{exp: exp, tag: tag});
  endtask

  // Monitor: pop and compare shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (queueQ.size() > 0) begin
        itemT it;
        logic [3:0] act;
        it = queueQ.pop_front();
        act = {busyLeftN, busyRightN, wrGateLeft, wrGateRight};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: {busyL,busyR,gateL,gateR} actual %b expected %b", it.tag, act, it.exp);
        end
        checks++;
        if (!busyLeftN && !busyRightN) begin
          errors++;
          $display("FAIL R5: both busy low, actual %b%b expected not 00", busyLeftN, busyRightN);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: outputs idle during reset
    @(negedge clk); #1;
    checks++;
    if ({busyLeftN, busyRightN} !== 2'b11) begin
      errors++;
      $display("FAIL R9: busy in reset actual %b%b expected 11", busyLeftN, busyRightN);
    end
    @(negedge clk); rstN = 1'b1;
    step(0, 1, 0, 1, 4'b1111, "R9");
    // R1: different addresses
    step(5, 0, 6, 0, 4'b1111, "R1");
    step(5, 0, 6, 0, 4'b1111, "R1");
    // R2: matching address, one enable high
    step(7, 0, 7, 1, 4'b1111, "R2");
    step(7, 0, 7, 1, 4'b1111, "R2");
    step(7, 1, 7, 0, 4'b1111, "R2");
    // R3/R6/R7: right settles first, left arrives later and loses
    step(3, 0, 9, 0, 4'b1111, "R1");
    step(3, 0, 9, 0, 4'b1111, "R1");
    step(9, 0, 9, 0, 4'b1101, "R6");
    step(9, 0, 9, 0, 4'b0101, "R3");
    for (int i = 0; i < 24; i++) step(9, 0, 9, 0, 4'b0101, "R7");
    // R8: address change ends contention
    step(4, 0, 9, 0, 4'b0111, "R8");
    step(4, 0, 9, 0, 4'b1111, "R8");
    // R4: both move together onto one address
    step(12, 0, 12, 0, 4'b1110, "R4");
    step(12, 0, 12, 0, 4'b1010, "R4");
    // R8: enable high ends contention
    step(12, 1, 12, 0, 4'b1011, "R8");
    step(12, 1, 12, 0, 4'b1111, "R8");
    // R3: left settles first, right arrives later and loses
    step(12, 0, 20, 0, 4'b1111, "R1");
    step(12, 0, 20, 0, 4'b1111, "R1");
    step(12, 0, 12, 0, 4'b1110, "R6");
    step(12, 0, 12, 0, 4'b1010, "R3");
    step(12, 0, 13, 0, 4'b1011, "R8");
    step(12, 0, 13, 0, 4'b1111, "R8");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule